// File: doc/BRIEF.md
# Quarter-wave sine DDS core

This block is a direct digital synthesizer. A phase accumulator advances by a programmable tuning word on every clock. A phase offset is added to the running phase, and the upper bits of the sum choose a sine amplitude. The result is a stream of offset-binary samples for an external DAC. The output frequency is `f_clk * tuning_word / 2^ACC_W`, so a smaller tuning word gives a lower frequency.

Only the first quarter of a sine period is stored, as a table of `2^(PHASE_W-2)` entries. The second-highest phase bit mirrors the table address by bitwise inversion. The highest phase bit drives a bank of XOR gates that complements the whole output word for the negative half-cycle. With `ACC_W = PHASE_W = 17`, the table address is 15 bits wide instead of the 16 bits a half-wave table needs, and the phase step is unchanged. The table is computed at elaboration time. Entries are `round((2^(AMP_W-1)-1) * sin)` taken at the centre of each quarter-wave step.

Top module: `dds_quarter_sine`

## Requirements
- R1: On every clock edge with reset low, the accumulator adds the registered tuning word modulo 2^ACC_W. A word of 2^ACC_W-1 therefore steps the phase backwards by one.
- R2: The tuning word register loads `tune_word` only at an edge where `tune_we` is high. The new word is first added at the following edge, and the accumulator is not cleared when it loads. While `tune_we` is low, `tune_word` has no effect.
- R3: An edge with `rst` high clears the accumulator and the tuning word register, and sets `sample` to mid-scale 2^(AMP_W-1).
- R4: The lookup phase index is the top PHASE_W bits of (accumulator + `phase_ofs`) mod 2^ACC_W. The offset is not accumulated.
- R5: For phase index p, `sample` lies within one LSB of y. With s = sin(2π(p+0.5)/2^PHASE_W) and A = 2^(AMP_W-1)-1, y = 2^(AMP_W-1) + A·s when s > 0, and y = 2^(AMP_W-1) - 1 + A·s otherwise.
- R6: The samples for phase indices p and p + 2^(PHASE_W-1) are bitwise complements, so they sum to 2^AMP_W - 1.
- R7: For p in the first half-cycle, the samples for p and 2^(PHASE_W-1) - 1 - p are equal, because the quarter-table address is mirrored.
- R8: The sample is 2^AMP_W - 1 at phase indices 2^(PHASE_W-2)-1 and 2^(PHASE_W-2). It is 0 at indices 3·2^(PHASE_W-2)-1 and 3·2^(PHASE_W-2).
- R9: A phase value present before edge k+1 reaches `sample` at edge k+2. Here the phase value is an accumulator value registered at edge k, combined with the offset then applied. The sample is unchanged after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tune_we | input | 1 | Load strobe for the tuning word register |
| tune_word | input | ACC_W | Phase increment to load |
| phase_ofs | input | ACC_W | Phase offset added before the lookup |
| sample | output | AMP_W | Registered offset-binary amplitude |

## Verification
The bench builds the core with a 17-bit accumulator, a 12-bit lookup phase and 12-bit samples, giving a 1024-entry quarter table. This leaves five accumulator bits below the lookup, so phase truncation, wrap-around and backward stepping all occur in short runs. With the tuning word held at zero, the offset input can place any of the 4096 phase indices directly. This brings the quadrant seams, the peak and trough entries, and the mirror and complement symmetries within reach of exact checks. All other samples are compared against a real-valued sine model.

// File: rtl/dds_pkg.sv
`timescale 1ns/1ps
package dds_pkg;

    // pi scaled by 2^30, rounded
    localparam longint PI_Q30   = 64'sd3373259426;
    localparam longint HALF_Q30 = 64'sd536870912;

    // Amplitude of quarter-table entry idx out of depth, scaled to peak.
    // Integer Taylor series in Q30, evaluated at the centre of the step.
    function automatic longint quarter_amp(input longint idx, input longint depth,
                                           input longint peak);
        longint x;
        longint x2;
        longint term;
        longint acc;
        longint amp;
        x    = ((64'sd2 * idx + 64'sd1) * PI_Q30) / (64'sd4 * depth);
        x2   = (x * x) >>> 30;
        term = x;
        acc  = x;
        for (int k = 1; k <= 7; k++) begin
            term = -((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1));
            acc  = acc + term;
        end
        amp = (acc * peak + HALF_Q30) >>> 30;
        if (amp > peak) amp = peak;
        if (amp < 64'sd0) amp = 64'sd0;
        return amp;
    endfunction

endpackage

// File: rtl/dds_phase_acc.sv
`timescale 1ns/1ps
module dds_phase_acc #(
    parameter int ACC_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tune_we,
    input  logic [ACC_W-1:0] tune_word,
    output logic [ACC_W-1:0] acc_q
);

    typedef struct packed {
        logic [ACC_W-1:0] step;
        logic [ACC_W-1:0] phase;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.phase = st_q.phase + st_q.step;
        if (tune_we) st_d.step = tune_word;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign acc_q = st_q.phase;

    // R2
    step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tune_we |=> $stable(st_q.step));

    // R1
    zero_step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.step == '0) |=> $stable(st_q.phase));

endmodule

// File: rtl/dds_quarter_rom.sv
`timescale 1ns/1ps
module dds_quarter_rom #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 11
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);

    localparam int     DEPTH = 1 << ADDR_W;
    localparam longint PEAK  = (64'sd1 <<< DATA_W) - 64'sd1;

    logic [DATA_W-1:0] tbl [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        localparam longint VAL = dds_pkg::quarter_amp(longint'(i), longint'(DEPTH), PEAK);
        assign tbl[i] = DATA_W'(VAL);
    end

    assign data = tbl[addr];

endmodule

// File: rtl/dds_wave_stage.sv
`timescale 1ns/1ps
module dds_wave_stage #(
    parameter int PHASE_W = 10,
    parameter int AMP_W   = 12,
    localparam int QA_W   = PHASE_W - 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] phase,
    output logic [QA_W-1:0]    rom_addr,
    input  logic [AMP_W-2:0]   rom_data,
    output logic [AMP_W-1:0]   sample
);

    localparam logic [AMP_W-1:0] MID = AMP_W'(1) << (AMP_W - 1);

    typedef struct packed {
        logic             neg_half;
        logic [AMP_W-2:0] mag;
        logic [AMP_W-1:0] out;
    } wave_state_t;

    wave_state_t st_d, st_q;

    always_comb begin
        // mirror the quarter address in the 2nd and 4th quarters
        rom_addr = phase[PHASE_W-2] ? ~phase[QA_W-1:0] : phase[QA_W-1:0];
        st_d          = st_q;
        st_d.neg_half = phase[PHASE_W-1];
        st_d.mag      = rom_data;
        // XOR bank: complement the whole offset-binary word in the lower half
        st_d.out      = {1'b1, st_q.mag} ^ {AMP_W{st_q.neg_half}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.neg_half <= 1'b0;
            st_q.mag      <= '0;
            st_q.out      <= MID;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample = st_q.out;

    // R6
    half_sign_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (st_q.out[AMP_W-1] == !$past(st_q.neg_half)));

endmodule

// File: rtl/dds_quarter_sine.sv
`timescale 1ns/1ps
module dds_quarter_sine #(
    parameter int ACC_W   = 17,
    parameter int PHASE_W = 10,
    parameter int AMP_W   = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tune_we,
    input  logic [ACC_W-1:0] tune_word,
    input  logic [ACC_W-1:0] phase_ofs,
    output logic [AMP_W-1:0] sample
);

    localparam int QA_W = PHASE_W - 2;
    localparam int DROP = ACC_W - PHASE_W;
    localparam logic [AMP_W-1:0] MID = AMP_W'(1) << (AMP_W - 1);

    logic [ACC_W-1:0]   acc_q;
    logic [ACC_W-1:0]   ph_sum;
    logic [PHASE_W-1:0] phase;
    logic [QA_W-1:0]    rom_addr;
    logic [AMP_W-2:0]   rom_data;

    dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .tune_we   (tune_we),
        .tune_word (tune_word),
        .acc_q     (acc_q)
    );

    assign ph_sum = acc_q + phase_ofs;
    assign phase  = PHASE_W'(ph_sum >> DROP);

    dds_quarter_rom #(.ADDR_W(QA_W), .DATA_W(AMP_W - 1)) u_rom (
        .addr (rom_addr),
        .data (rom_data)
    );

    dds_wave_stage #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_wave (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .rom_addr (rom_addr),
        .rom_data (rom_data),
        .sample   (sample)
    );

    // R3
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (sample == MID) && (acc_q == '0));

endmodule

// File: tb/tb_dds_quarter_sine.sv
`timescale 1ns/1ps
module tb_dds_quarter_sine;

    localparam int  ACC_W   = 17;
    localparam int  PHASE_W = 12;
    localparam int  AMP_W   = 12;
    localparam int  SH      = ACC_W - PHASE_W;
    localparam int  NPH     = 1 << PHASE_W;
    localparam int  QTR     = NPH / 4;
    localparam int  MID     = 1 << (AMP_W - 1);
    localparam int  TOP     = (1 << AMP_W) - 1;
    localparam real PEAK    = real'(MID - 1);
    localparam real PI      = 3.14159265358979;

    // {tuning word, phase offset, cycles to observe}
    localparam int NVEC = 7;
    localparam int VEC [NVEC][3] = '{
        '{1,      0,     60},
        '{32,     0,     200},
        '{1000,   0,     200},
        '{65536,  0,     20},
        '{131071, 0,     100},
        '{12345,  777,   200},
        '{4097,   70000, 150}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tune_we = 1'b0;
    logic [ACC_W-1:0] tune_word = '0;
    logic [ACC_W-1:0] phase_ofs = '0;
    logic [AMP_W-1:0] sample;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    dds_quarter_sine #(.ACC_W(ACC_W), .PHASE_W(PHASE_W), .AMP_W(AMP_W)) dut (
        .clk       (clk),
        .rst       (rst),
        .tune_we   (tune_we),
        .tune_word (tune_word),
        .phase_ofs (phase_ofs),
        .sample    (sample)
    );

    // Reference model from the requirements
    logic [ACC_W-1:0] acc_m = '0;
    logic [ACC_W-1:0] tw_m = '0;
    logic [ACC_W-1:0] sum_m;
    int ph1 = 0, ph2 = 0;
    bit v1 = 1'b0, v2 = 1'b0;

    assign sum_m = acc_m + phase_ofs;

    always @(posedge clk) begin
        if (rst) begin
            acc_m <= '0; tw_m <= '0; v1 <= 1'b0; v2 <= 1'b0;
        end else begin
            acc_m <= acc_m + tw_m;           // R1
            if (tune_we) tw_m <= tune_word;  // R2
            ph1 <= int'(sum_m >> SH);        // R4
            v1  <= 1'b1;
            ph2 <= ph1;
            v2  <= v1;
        end
    end

    function automatic real model_y(int p);
        real s;
        s = $sin(2.0 * PI * (real'(p) + 0.5) / real'(NPH));
        return (s > 0.0) ? real'(MID) + PEAK * s : real'(MID) - 1.0 + PEAK * s;
    endfunction

    task automatic check_exact(int got, int exp, string req);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    task automatic tick_check(string req);
        real y, d;
        @(negedge clk);
        if (!v2) begin
            check_exact(int'(sample), MID, req);
        end else begin
            y = model_y(ph2);
            d = real'(sample) - y;
            checks++;
            if (d > 1.0 || d < -1.0) begin
                failures++;
                $display("FAIL %s phase=%0d got=%0d exp=%f", req, ph2, sample, y);
            end
        end
    endtask

    task automatic read_at(int p, output int val);
        phase_ofs = ACC_W'(p << SH);
        repeat (3) @(negedge clk);
        val = int'(sample);
    endtask

    initial begin
        int a, b;
        // R3: reset state
        repeat (3) @(negedge clk);
        check_exact(int'(sample), MID, "R3 reset");
        rst = 1'b0;

        // vector walk: R1 stepping, R2 loading/ignore, R4 offset, R5 shape
        for (int v = 0; v < NVEC; v++) begin
            tick_check("R5");
            tune_we   = 1'b1;
            tune_word = ACC_W'(VEC[v][0]);
            phase_ofs = ACC_W'(VEC[v][1]);
            tick_check("R2");
            tune_we   = 1'b0;
            tune_word = ~ACC_W'(VEC[v][0]);  // R2: must be ignored
            for (int c = 0; c < VEC[v][2]; c++) tick_check("R1 R4 R5");
        end

        // R3: reset in mid-run
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_exact(int'(sample), MID, "R3 midrun");
        rst = 1'b0;
        for (int c = 0; c < 10; c++) tick_check("R3 after");

        // R8: extremes at quadrant seams (tuning word is zero after reset)
        read_at(QTR - 1, a);     check_exact(a, TOP, "R8 peak");
        read_at(QTR, a);         check_exact(a, TOP, "R8 peak");
        read_at(3 * QTR - 1, a); check_exact(a, 0, "R8 trough");
        read_at(3 * QTR, a);     check_exact(a, 0, "R8 trough");

        // R6: complement across half a cycle
        for (int p = 0; p < NPH / 2; p += 97) begin
            read_at(p, a);
            read_at(p + NPH / 2, b);
            check_exact(a + b, TOP, "R6");
        end
        read_at(NPH / 2 - 1, a); check_exact(a, MID + 2, "R6 seam");
        read_at(NPH / 2, a);     check_exact(a, MID - 3, "R6 seam");

        // R7: mirror within the first half-cycle
        for (int p = 0; p < QTR; p += 61) begin
            read_at(p, a);
            read_at(NPH / 2 - 1 - p, b);
            check_exact(a, b, "R7");
        end

        // R9: two-edge latency from phase to sample
        read_at(0, a);
        check_exact(a, MID + 2, "R9 base");
        phase_ofs = ACC_W'((QTR - 1) << SH);
        @(negedge clk);
        check_exact(int'(sample), MID + 2, "R9 one edge");
        @(negedge clk);
        check_exact(int'(sample), TOP, "R9 two edges");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog got=timeout exp=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule